// File: doc/BRIEF.md
# Double-Pumped Unified Memory Port

This block lets one single-ported storage array serve a processor's instruction fetch and its data access within the same processor cycle. It runs on a fast clock at twice the processor rate. Each processor cycle is split into two fast cycles. The first fast cycle reads the instruction word. The second fast cycle either reads a data word or, when the write enable is set, writes one.

Every 32-bit word is kept in two 16-bit banks. The upper half goes to the high bank and the lower half to the low bank. Both banks share one address and one write strobe. The fetched instruction is captured in a hold register when the first fast cycle ends, so the second access cannot disturb it. The read data is captured when the second fast cycle ends. Both results are valid when the processor cycle ends.

The block synchronizes the release of its reset and drives a phase output. The processor side uses that output to align its cycles with the fast clock. Addresses count words, and the depth is a parameter that must be a power of two.

Top module: `dpmem_port`

## Requirements
- R1: While reset is applied, and until the first capture after release, `instr_o` and `rd_data_o` read 0 and `phase_o` reads 0.
- R2: After reset release, `phase_o` alternates on every fast clock edge. It is 0 during the fetch half of a processor cycle and 1 during the data half.
- R3: At the fast edge that ends the fetch half, `instr_o` loads the 32-bit word stored at `instr_addr`.
- R4: `instr_o` keeps its value across the edge that ends the data half, whatever the data access does.
- R5: At the edge that ends the data half with `wr_en` low, `rd_data_o` loads the word stored at `data_addr`.
- R6: At the edge that ends the data half with `wr_en` high, `wr_data[31:16]` is written to the high bank and `wr_data[15:0]` to the low bank, both at `data_addr`, and `rd_data_o` keeps its value.
- R7: `wr_en` has no effect while `phase_o` is 0. A strobe that is dropped before the data-half edge writes nothing.
- R8: When a fetch and a write hit the same address in one processor cycle, the fetch returns the old word. The next fetch of that address returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Clock at twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| phase_o | output | 1 | 0 in the fetch half, 1 in the data half |
| instr_addr | input | $clog2(DEPTH) | Word address for instruction fetch |
| data_addr | input | $clog2(DEPTH) | Word address for data read or write |
| wr_data | input | 32 | Word to write |
| wr_en | input | 1 | Write request for the data half |
| instr_o | output | 32 | Fetched instruction word |
| rd_data_o | output | 32 | Data word read in the data half |

## Verification
An instruction fetch and a data write can land on the same word in one processor cycle. The bench provokes this with directed cases and with random cycles that force the data address onto the fetch address. It checks that the fetch returns the word from before the write and that the following fetch of that address returns the new word. It also judges a write strobe that is present only in the fetch half, by reading the target address back in a later cycle.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int NBANK  = 2;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/dpmem_phase.sv
module dpmem_phase
  import dpmem_pkg::*;
(
  input  logic   fast_clk,
  input  logic   rst_n,
  output logic   rst_ok,
  output phase_e phase
);
  logic [1:0] sync_q;
  phase_e     phase_d;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];

  always_comb begin
    phase_d = (phase == PH_FETCH) ? PH_DATA : PH_FETCH;
  end

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n)      phase <= PH_FETCH;
    else if (rst_ok) phase <= phase_d;
  end

  // R2: phase flips on every edge once reset is released
  p_phase_toggle_r2: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    $past(rst_ok) |-> (phase != $past(phase)));
endmodule

// File: rtl/dpmem_sched.sv
module dpmem_sched
  import dpmem_pkg::*;
#(
  parameter int AW = 8
) (
  input  phase_e        phase,
  input  logic [AW-1:0] iaddr,
  input  logic [AW-1:0] daddr,
  input  logic          wr_en,
  output logic [AW-1:0] bank_addr,
  output logic          bank_we,
  output logic          cap_instr,
  output logic          cap_data
);
  always_comb begin
    bank_addr = iaddr;
    bank_we   = 1'b0;
    cap_instr = 1'b0;
    cap_data  = 1'b0;
    unique case (phase)
      PH_FETCH: begin
        bank_addr = iaddr;
        cap_instr = 1'b1;
      end
      PH_DATA: begin
        bank_addr = daddr;
        bank_we   = wr_en;
        cap_data  = !wr_en;
      end
    endcase
  end
endmodule

// File: rtl/dpmem_bank.sv
module dpmem_bank #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdat,
  output logic [W-1:0]  rdat
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdat;
  end

  assign rdat = store[addr];

  // R6: a strobed write lands in this bank at the strobed address
  p_bank_write_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    we |=> (store[$past(addr)] == $past(wdat)));
endmodule

// File: rtl/dpmem_port.sv
module dpmem_port
  import dpmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              fast_clk,
  input  logic              rst_n,
  output logic              phase_o,
  input  logic [AW-1:0]     instr_addr,
  input  logic [AW-1:0]     data_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [WORD_W-1:0] instr_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic              rst_ok;
  phase_e            phase;
  logic [AW-1:0]     bank_addr;
  logic              bank_we;
  logic              cap_instr;
  logic              cap_data;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] instr_q, instr_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  dpmem_phase u_phase (
    .fast_clk (fast_clk),
    .rst_n    (rst_n),
    .rst_ok   (rst_ok),
    .phase    (phase)
  );

  dpmem_sched #(.AW(AW)) u_sched (
    .phase     (phase),
    .iaddr     (instr_addr),
    .daddr     (data_addr),
    .wr_en     (wr_en),
    .bank_addr (bank_addr),
    .bank_we   (bank_we),
    .cap_instr (cap_instr),
    .cap_data  (cap_data)
  );

  // bank 0 holds the low half, bank 1 the high half
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    dpmem_bank #(.DEPTH(DEPTH), .W(HALF_W)) u_bank (
      .clk    (fast_clk),
      .rst_ok (rst_ok),
      .addr   (bank_addr),
      .we     (bank_we),
      .wdat   (wr_data[g*HALF_W +: HALF_W]),
      .rdat   (rd_word[g*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    instr_d = cap_instr ? rd_word : instr_q;
    rdata_d = cap_data  ? rd_word : rdata_q;
  end

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      rdata_q <= '0;
    end else if (rst_ok) begin
      instr_q <= instr_d;
      rdata_q <= rdata_d;
    end
  end

  assign phase_o   = phase;
  assign instr_o   = instr_q;
  assign rd_data_o = rdata_q;

  // R3: the fetch half loads the array word
  p_instr_load_r3: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    (phase == PH_FETCH) |=> (instr_q == $past(rd_word)));

  // R4: the data half leaves the instruction alone
  p_instr_hold_r4: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    (phase == PH_DATA) |=> $stable(instr_q));

  // R5: a data read loads the array word
  p_rdata_load_r5: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    (phase == PH_DATA && !wr_en) |=> (rdata_q == $past(rd_word)));

  // R6: a write keeps the previous read result
  p_rdata_hold_r6: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    (phase == PH_DATA && wr_en) |=> $stable(rdata_q));

  // R7: no array write during the fetch half
  p_no_fetch_write_r7: assert property (@(posedge fast_clk) disable iff (!rst_ok)
    (phase == PH_FETCH) |-> !bank_we);
endmodule

// File: tb/dpmem_port_bench.sv
module dpmem_port_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          phase_o;
  logic [AW-1:0] instr_addr;
  logic [AW-1:0] data_addr;
  logic [31:0]   wr_data;
  logic          wr_en;
  logic [31:0]   instr_o;
  logic [31:0]   rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [DEPTH];

  always #5 clk = ~clk;

  dpmem_port #(.DEPTH(DEPTH)) u_dpmem_port (
    .fast_clk   (clk),
    .rst_n      (rst_n),
    .phase_o    (phase_o),
    .instr_addr (instr_addr),
    .data_addr  (data_addr),
    .wr_data    (wr_data),
    .wr_en      (wr_en),
    .instr_o    (instr_o),
    .rd_data_o  (rd_data_o)
  );

  function automatic logic [31:0] fill_word(input int a);
    return {16'(a * 37 + 16'h1200), 16'(~(a * 11))};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entry and exit: at a negedge inside the fetch half
  task automatic proc_cycle(input logic [AW-1:0] ia, input logic [AW-1:0] da,
                            input logic we, input logic [31:0] wd,
                            input logic fetch_only_we);
    logic [31:0] exp_i;
    logic [31:0] prev_r;
    string       ireq;
    instr_addr = ia;
    data_addr  = da;
    wr_data    = wd;
    wr_en      = we | fetch_only_we;
    exp_i      = model[ia];
    prev_r     = rd_data_o;
    ireq       = (we && ia == da) ? "R8" : "R3";
    @(negedge clk);
    check(phase_o == 1'b1, "R2", 32'(phase_o), 32'd1);
    check(instr_o == exp_i, ireq, instr_o, exp_i);
    if (fetch_only_we) wr_en = 1'b0;
    @(negedge clk);
    check(phase_o == 1'b0, "R2", 32'(phase_o), 32'd0);
    check(instr_o == exp_i, "R4", instr_o, exp_i);
    if (we) begin
      model[da] = wd;
      check(rd_data_o == prev_r, "R6", rd_data_o, prev_r);
    end else begin
      check(rd_data_o == model[da], "R5", rd_data_o, model[da]);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic          w;
    logic [31:0]   d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; instr_addr = '0; data_addr = '0; wr_data = '0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(instr_o == 32'd0, "R1", instr_o, 32'd0);
    check(rd_data_o == 32'd0, "R1", rd_data_o, 32'd0);
    check(phase_o == 1'b0, "R1", 32'(phase_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(phase_o == 1'b0, "R1", 32'(phase_o), 32'd0);
    check(instr_o == 32'd0, "R1", instr_o, 32'd0);
    while (phase_o != 1'b1) @(negedge clk);
    @(negedge clk);
    // fill every word
    for (int i = 0; i < DEPTH; i++) begin
      proc_cycle(AW'(i), AW'(i), 1'b1, fill_word(i), 1'b0);
    end
    // R6 distinct halves read back as one word
    proc_cycle(8'd3, 8'd200, 1'b1, 32'hDEAD_0001, 1'b0);
    proc_cycle(8'd200, 8'd200, 1'b0, 32'd0, 1'b0);
    // R8 collision then refetch
    proc_cycle(8'd9, 8'd9, 1'b1, 32'h1357_9BDF, 1'b0);
    proc_cycle(8'd9, 8'd1, 1'b0, 32'd0, 1'b0);
    // R7 strobe only in fetch half: word must stay unchanged
    proc_cycle(8'd4, 8'd77, 1'b0, 32'hFFFF_FFFF, 1'b1);
    proc_cycle(8'd77, 8'd77, 1'b0, 32'd0, 1'b0);
    check(rd_data_o == fill_word(77), "R7", rd_data_o, fill_word(77));
    // boundary addresses
    proc_cycle(AW'(DEPTH-1), AW'(DEPTH-1), 1'b1, 32'h8000_0001, 1'b0);
    proc_cycle(8'd0, AW'(DEPTH-1), 1'b0, 32'd0, 1'b0);
    // random mix, some with data address forced onto fetch address
    for (int n = 0; n < 600; n++) begin
      a = AW'($urandom);
      b = ($urandom % 4 == 0) ? a : AW'($urandom);
      w = ($urandom % 3 == 0);
      d = $urandom;
      proc_cycle(a, b, w, d, ($urandom % 10 == 0) && !w);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule